// File: doc/BRIEF.md
# Multimodulus Clock Prescaler (32/33/47/48)

This block divides a fast input clock by one of four ratios: 32, 33, 47 or 48. The front stage is a cell that divides by either two or three, and a chain of four halving stages follows it. Each output period therefore spans sixteen cycles of the front cell. A small gate picks, for each of those sixteen cycles, whether the cell counts two or three input clocks.

A band input picks the low pair of ratios (32/33) or the high pair (47/48). It does this by flipping the sense of the gate that drives the front cell, so the high pair needs no extra storage. A ratio input picks the ratio within the pair. In the low band, at most one of the sixteen cell cycles is a three-count. In the high band, at most one of them is a two-count. That one odd cycle always falls on the last cell cycle of the period, when all four halving stages are at their terminal count.

The model is a synchronous equivalent of the rippling chain. Every stage runs on the input clock and moves on a one-cycle enable. Both control inputs are captured at the period boundary, so a single output period never mixes two ratios.

Top module: `mmod_prescaler`

## Requirements
- R1: With `band_hi`=0 and `mode_ctl`=1, the period of `div_out` (rising edge to rising edge) is 32 input clocks.
- R2: With `band_hi`=0 and `mode_ctl`=0, the period is 33 input clocks: fifteen cell cycles of 2 and one of 3.
- R3: With `band_hi`=1 and `mode_ctl`=1, the period is 48 input clocks: all sixteen cell cycles are 3.
- R4: With `band_hi`=1 and `mode_ctl`=0, the period is 47 input clocks: fifteen cell cycles of 3 and one of 2.
- R5: The odd cell cycle is the last of the period. `div_out` is high for the first eight cell cycles and low for the last eight. The high phase is therefore 16 clocks in the low band and 24 in the high band, whatever the value of `mode_ctl`.
- R6: `band_hi` and `mode_ctl` are sampled only on the clock edge where `div_out` rises, and while reset is held. A change at any other time has no effect on the period in progress.
- R7: Reset is synchronous and active high. While it is held, `div_out` is 1. The first period after release uses the input values present on the last reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| band_hi | input | 1 | 0 selects the 32/33 pair, 1 selects the 47/48 pair |
| mode_ctl | input | 1 | 1 selects 32 or 48, 0 selects 33 or 47 |
| div_out | output | 1 | Divided clock; rises at each period boundary |

## Verification
Each of the four band/ratio pairs is held for several periods. The measured lengths of 32, 33, 47 and 48 show which way the band flips the cell control, and whether the one odd cycle is added or removed. The width of the high phase tells an odd cycle at the end of the period from one placed earlier. The random phase changes the inputs at arbitrary points inside a period, so a period that follows new values too early shows up. A reset in the middle of a run, with fresh values applied, confirms that the first period after reset follows the values held during reset.

// File: rtl/mmod_pkg.sv
package mmod_pkg;

  typedef enum logic {BAND_LOW = 1'b0, BAND_HIGH = 1'b1} band_e;

  // Total input clocks in one output period for a band / ratio pair.
  function automatic int unsigned period_len(logic band, logic mode, int unsigned cells);
    int unsigned base;
    base = (band == BAND_HIGH) ? 3 * cells : 2 * cells;
    if (!mode) begin
      base = (band == BAND_HIGH) ? base - 1 : base + 1;
    end
    return base;
  endfunction

  // Input clocks spent in the first half of the period (no odd cycle there).
  function automatic int unsigned high_len(logic band, int unsigned cells);
    return (cells / 2) * ((band == BAND_HIGH) ? 3 : 2);
  endfunction

endpackage

// File: rtl/mmod_cell23.sv
module mmod_cell23 (
  input  logic clk,
  input  logic rst,
  input  logic div3,
  output logic tick
);
  logic [1:0] cnt;
  logic       last;

  assign last = div3 ? (cnt == 2'd2) : (cnt == 2'd1);
  assign tick = last;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= 2'd0;
    else if (last) cnt <= 2'd0;
    else           cnt <= cnt + 2'd1;
  end

  // The third count is only reached while the gate asks for a three-count.
  AST_CELL_THIRD: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd2) |-> div3); // R2
  AST_CELL_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt != 2'd3); // R3

endmodule

// File: rtl/mmod_div2_chain.sv
module mmod_div2_chain #(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [STAGES-1:0] stage,
  output logic              term,
  output logic              wrap
);
  logic [STAGES:0] carry;

  assign carry[0] = tick;

  for (genvar i = 0; i < STAGES; i++) begin : g_half
    assign carry[i+1] = carry[i] & stage[i];
    always_ff @(posedge clk) begin
      if (rst)           stage[i] <= 1'b0;
      else if (carry[i]) stage[i] <= ~stage[i];
    end
  end

  assign term = &stage;
  assign wrap = carry[STAGES];

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(stage)); // R5

endmodule

// File: rtl/mmod_mode_gate.sv
module mmod_mode_gate (
  input  logic clk,
  input  logic rst,
  input  logic band_in,
  input  logic mode_in,
  input  logic period_end,
  input  logic term,
  output logic band_q,
  output logic mode_q,
  output logic div3
);
  logic gate_n;

  always_ff @(posedge clk) begin
    if (rst || period_end) begin
      band_q <= band_in;
      mode_q <= mode_in;
    end
  end

  // Low only on the last cell cycle when the odd cycle is requested.
  assign gate_n = ~(~mode_q & term);
  // The band flips the meaning of the gate: three-count when the gate is low
  // in the low band, when it is high in the high band.
  assign div3 = band_q ? gate_n : ~gate_n;

  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> ($stable(band_q) && $stable(mode_q))); // R6

endmodule

// File: rtl/mmod_prescaler.sv
module mmod_prescaler #(
  parameter int unsigned STAGES = 4
) (
  input  logic clk_in,
  input  logic rst,
  input  logic band_hi,
  input  logic mode_ctl,
  output logic div_out
);
  import mmod_pkg::*;

  localparam int unsigned CELLS = 1 << STAGES;
  localparam int unsigned CW    = $clog2(3 * CELLS + 1);

  logic              cell_tick;
  logic              cell_div3;
  logic [STAGES-1:0] stage;
  logic              stage_term;
  logic              period_end;
  logic              band_q;
  logic              mode_q;
  logic [CW-1:0]     per_cnt;

  mmod_cell23 u_cell (
    .clk  (clk_in),
    .rst  (rst),
    .div3 (cell_div3),
    .tick (cell_tick)
  );

  mmod_div2_chain #(.STAGES(STAGES)) u_chain (
    .clk   (clk_in),
    .rst   (rst),
    .tick  (cell_tick),
    .stage (stage),
    .term  (stage_term),
    .wrap  (period_end)
  );

  mmod_mode_gate u_gate (
    .clk        (clk_in),
    .rst        (rst),
    .band_in    (band_hi),
    .mode_in    (mode_ctl),
    .period_end (period_end),
    .term       (stage_term),
    .band_q     (band_q),
    .mode_q     (mode_q),
    .div3       (cell_div3)
  );

  assign div_out = ~stage[STAGES-1];

  // Cycles elapsed in the current period, used only by the checks below.
  always_ff @(posedge clk_in) begin
    if (rst || period_end) per_cnt <= '0;
    else                   per_cnt <= per_cnt + 1'b1;
  end

  AST_LEN_LOW_EVEN: assert property (@(posedge clk_in) disable iff (rst)
    (period_end && !band_q && mode_q) |-> (32'(per_cnt) + 1 == period_len(1'b0, 1'b1, CELLS))); // R1
  AST_LEN_LOW_ODD: assert property (@(posedge clk_in) disable iff (rst)
    (period_end && !band_q && !mode_q) |-> (32'(per_cnt) + 1 == period_len(1'b0, 1'b0, CELLS))); // R2
  AST_LEN_HIGH_FULL: assert property (@(posedge clk_in) disable iff (rst)
    (period_end && band_q && mode_q) |-> (32'(per_cnt) + 1 == period_len(1'b1, 1'b1, CELLS))); // R3
  AST_LEN_HIGH_SHORT: assert property (@(posedge clk_in) disable iff (rst)
    (period_end && band_q && !mode_q) |-> (32'(per_cnt) + 1 == period_len(1'b1, 1'b0, CELLS))); // R4
  AST_HIGH_PHASE: assert property (@(posedge clk_in) disable iff (rst)
    $fell(div_out) |-> (32'(per_cnt) == high_len(band_q, CELLS))); // R5
  AST_RESET_HIGH: assert property (@(posedge clk_in)
    rst |=> div_out); // R7

endmodule

// File: tb/mmod_prescaler_bench.sv
`timescale 1ns/1ps
module mmod_prescaler_bench;

  logic clk_in = 1'b0;
  logic rst = 1'b1;
  logic band_hi = 1'b0;
  logic mode_ctl = 1'b1;
  logic div_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_in = ~clk_in;

  mmod_prescaler u_mmod_prescaler (
    .clk_in   (clk_in),
    .rst      (rst),
    .band_hi  (band_hi),
    .mode_ctl (mode_ctl),
    .div_out  (div_out)
  );

  // Expected period: sixteen cell cycles of 2 or 3, plus or minus the odd one.
  function automatic int exp_period(logic b, logic m);
    int cyc;
    cyc = b ? 3 : 2;
    if (m) return 16 * cyc;
    return 15 * cyc + (b ? 2 : 3);
  endfunction

  function automatic int exp_high(logic b);
    return b ? 8 * 3 : 8 * 2;
  endfunction

  function automatic string tag_of(logic b, logic m);
    if (!b && m)  return "R1";
    if (!b && !m) return "R2";
    if (b && m)   return "R3";
    return "R4";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // Period monitor, sampling one nanosecond after each rising edge.
  int   cnt = 0;
  logic prev = 1'b1;
  logic cur_b = 1'b0;
  logic cur_m = 1'b1;
  bit   first = 1'b1;

  always @(posedge clk_in) begin
    #1;
    if (rst) begin
      cnt   = 0;
      prev  = div_out;
      cur_b = band_hi;
      cur_m = mode_ctl;
      first = 1'b1;
    end else begin
      cnt++;
      if (prev && !div_out) begin
        check(cnt == exp_high(cur_b), "R5 high phase", cnt, exp_high(cur_b));
      end
      if (!prev && div_out) begin
        string t;
        t = tag_of(cur_b, cur_m);
        if (first) t = {t, "/R7 first period"};
        if (band_hi != cur_b || mode_ctl != cur_m) t = {t, "/R6 mid-period change"};
        check(cnt == exp_period(cur_b, cur_m), t, cnt, exp_period(cur_b, cur_m));
        cur_b = band_hi;
        cur_m = mode_ctl;
        cnt   = 0;
        first = 1'b0;
      end
      if (cnt > 200) begin
        check(1'b0, "watchdog: no edge on div_out", cnt, 48);
        finish_run();
      end
      prev = div_out;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_in);
    check(1'b0, "watchdog: run too long", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4177));
    // R7: output high while reset is held.
    repeat (4) @(negedge clk_in);
    check(div_out == 1'b1, "R7 reset state", int'(div_out), 1);
    @(negedge clk_in);
    rst = 1'b0;

    // Directed: each band / ratio pair for several periods.
    for (int k = 0; k < 4; k++) begin
      repeat (110) @(negedge clk_in);
      band_hi  = k[1];
      mode_ctl = ~k[0];
    end
    repeat (110) @(negedge clk_in);

    // Random changes at arbitrary points inside a period (R6).
    for (int k = 0; k < 40; k++) begin
      repeat (5 + ($urandom % 60)) @(negedge clk_in);
      band_hi  = 1'($urandom % 2);
      mode_ctl = 1'($urandom % 2);
    end

    // Reset in the middle of a run with fresh values (R7).
    @(negedge clk_in);
    rst = 1'b1;
    band_hi = 1'b1;
    mode_ctl = 1'b0;
    repeat (3) @(negedge clk_in);
    check(div_out == 1'b1, "R7 reset state mid-run", int'(div_out), 1);
    rst = 1'b0;

    for (int k = 0; k < 20; k++) begin
      repeat (5 + ($urandom % 80)) @(negedge clk_in);
      band_hi  = 1'($urandom % 2);
      mode_ctl = 1'($urandom % 2);
    end
    repeat (150) @(negedge clk_in);
    finish_run();
  end

endmodule